// File: doc/BRIEF.md
# Refresh Counter Test Sequencer

This block is a built-in test engine that verifies the internal refresh row counter of a DRAM. The DRAM is reached through a separate access controller, which this engine drives with one command at a time. There are four command kinds:

- a plain write to a given row and column;
- a plain read from a given row and column;
- a counter-mode read-write, in which the device's own refresh counter picks the row and the engine supplies only the column;
- an initialisation cycle, which also advances that counter.

After `start`, the engine first issues the required initialisation cycles. It then runs two passes, the first with an all-zero base pattern P and the second with its complement. Each pass has five steps:

1. Fill every cell with P.
2. Run one counter-mode read-write per row on a single chosen column, expecting P and writing ~P.
3. Read the whole array back. The chosen column must now hold ~P and every other column must hold P.
4. Run another counter-mode sweep on the same column, expecting ~P and writing P.
5. Read the whole array back, expecting P everywhere.

A counter that skips rows, repeats rows or stalls leaves a cell of the column untouched or touched twice, and the read-backs or the counter sweeps expose it. The first mismatch freezes the engine and records where it happened. Otherwise the engine ends with `pass` set. The array size is a parameter, so a small array can stand in for the real one.

Top module: `refcnt_test_seq`

## Requirements
- R1: After an accepted `start`, exactly INIT_CYCLES commands with op code 3 (initialisation) are issued before any other command.
- R2: The fill step issues one op code 0 (write) per cell, ROWS*COLS in total. The cells are visited in row-major order, with the column innermost. The write data is all zeros in the first pass and all ones in the second.
- R3: A counter sweep issues ROWS commands with op code 2 (counter read-write). Every one of them carries the column sampled at `start`.
- R4: A read-back issues one op code 1 (read) per cell in row-major order. After the first counter sweep of a pass, the expected word is ~P in the test column and P elsewhere. After the second counter sweep, P is expected everywhere.
- R5: In each pass, the first counter sweep expects P and writes ~P, and the second expects ~P and writes P.
- R6: The second pass repeats all five steps with the complement pattern. The step code is 1 to 5 in the first pass and 6 to 10 in the second, in the order fill, sweep A, read-back A, sweep B, read-back B.
- R7: The first mismatch between a returned word and the expected word latches four values: the step code, the index within the step, the expected word and the returned word. It then sets `fail` and no further command is issued.
- R8: When the sequence ends, `done` is set and `busy` is clear. The sequence ends either by completing all ten steps or by stopping on a mismatch. `pass` is set only on completion without a mismatch.
- R9: A command is held with stable fields until `cmd_ready` is seen. After a read or counter read-write command is accepted, no new command is issued until `rsp_valid` returns its word.
- R10: While the engine is busy, a `start` pulse has no effect. A change of `test_col` during a run does not change the column used by the counter sweeps.
- R11: After reset, `busy`, `done`, `pass`, `fail` and `cmd_valid` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a test run when idle or finished |
| test_col | input | log2(COLS) | Column used by the counter sweeps, sampled at start |
| cmd_valid | output | 1 | Command present |
| cmd_ready | input | 1 | Controller accepts the command this cycle |
| cmd_op | output | 2 | 0 write, 1 read, 2 counter read-write, 3 initialisation |
| cmd_row | output | log2(ROWS) | Row for write and read, zero otherwise |
| cmd_col | output | log2(COLS) | Column for write, read and counter read-write |
| cmd_wdata | output | DATA_W | Word to write |
| rsp_valid | input | 1 | Returned word present |
| rsp_rdata | input | DATA_W | Returned word |
| busy | output | 1 | Run in progress |
| done | output | 1 | Run finished, with or without a mismatch |
| pass | output | 1 | Run finished with no mismatch |
| fail | output | 1 | A mismatch stopped the run |
| fail_step | output | 4 | Step code of the first mismatch |
| fail_index | output | log2(ROWS*COLS) | Command index within that step |
| fail_expect | output | DATA_W | Expected word at the mismatch |
| fail_actual | output | DATA_W | Returned word at the mismatch |

## Verification
The assertions assume that the controller returns exactly one `rsp_valid` pulse for each accepted read or counter read-write. They also assume that it never raises `rsp_valid` when no such command is outstanding, and never raises `cmd_ready` without `cmd_valid`. The bench's controller model keeps to this: it raises `cmd_ready` only against a held command after a programmed gap, and it answers once after a programmed delay. Its refresh counter starts at an arbitrary row. It can be made to stall, to skip rows, or to hold a stuck bit in one cell, and each of these faults has a step, index and word pair that the bench works out by hand.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef enum logic [1:0] {
        OP_WRITE   = 2'd0,
        OP_READ    = 2'd1,
        OP_CNT_RW  = 2'd2,
        OP_INIT    = 2'd3
    } rtc_op_e;

    typedef enum logic [2:0] {
        ST_FILL    = 3'd0,
        ST_CNT_A   = 3'd1,
        ST_READ_A  = 3'd2,
        ST_CNT_B   = 3'd3,
        ST_READ_B  = 3'd4
    } rtc_step_e;

    typedef enum logic [2:0] {
        S_IDLE,
        S_INIT,
        S_ISSUE,
        S_WAIT,
        S_DONE,
        S_STOP
    } rtc_state_e;

    localparam int STEPS_PER_PASS = 5;

endpackage

// File: rtl/rtc_addr_walker.sv
module rtc_addr_walker #(
    parameter int ROWS = 8,
    parameter int COLS = 4
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clear,
    input  logic                           adv,
    input  logic                           sweep_cols,
    output logic [$clog2(ROWS)-1:0]        row,
    output logic [$clog2(COLS)-1:0]        col,
    output logic [$clog2(ROWS*COLS)-1:0]   idx,
    output logic                           last
);
    localparam int ROW_W = $clog2(ROWS);
    localparam int COL_W = $clog2(COLS);
    localparam int IDX_W = $clog2(ROWS * COLS);
    localparam logic [ROW_W-1:0] ROW_MAX = ROW_W'(ROWS - 1);
    localparam logic [COL_W-1:0] COL_MAX = COL_W'(COLS - 1);

    logic row_end;
    logic col_end;

    assign row_end = (row == ROW_MAX);
    assign col_end = (col == COL_MAX);
    assign last    = row_end && (!sweep_cols || col_end);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row <= '0;
            col <= '0;
            idx <= '0;
        end else if (clear) begin
            row <= '0;
            col <= '0;
            idx <= '0;
        end else if (adv) begin
            idx <= idx + IDX_W'(1);
            if (sweep_cols) begin
                if (col_end) begin
                    col <= '0;
                    row <= row_end ? '0 : row + ROW_W'(1);
                end else begin
                    col <= col + COL_W'(1);
                end
            end else begin
                row <= row_end ? '0 : row + ROW_W'(1);
            end
        end
    end

endmodule

// File: rtl/rtc_pattern_gen.sv
module rtc_pattern_gen
    import rtc_pkg::*;
#(
    parameter int COLS   = 4,
    parameter int DATA_W = 8
) (
    input  rtc_step_e                 step,
    input  logic                      phase,
    input  logic [$clog2(COLS)-1:0]   walk_col,
    input  logic [$clog2(COLS)-1:0]   lock_col,
    output rtc_op_e                   op,
    output logic [$clog2(COLS)-1:0]   col,
    output logic [DATA_W-1:0]         wdata,
    output logic [DATA_W-1:0]         expect_data,
    output logic                      needs_rsp,
    output logic                      sweep
);
    logic [DATA_W-1:0] base;
    logic              on_lock;

    assign base    = phase ? {DATA_W{1'b1}} : {DATA_W{1'b0}};
    assign on_lock = (walk_col == lock_col);

    always_comb begin
        op          = OP_WRITE;
        col         = walk_col;
        wdata       = base;
        expect_data = base;
        needs_rsp   = 1'b0;
        sweep       = 1'b1;
        unique case (step)
            ST_FILL: begin
                op    = OP_WRITE;
                wdata = base;
            end
            ST_CNT_A: begin
                op          = OP_CNT_RW;
                col         = lock_col;
                sweep       = 1'b0;
                needs_rsp   = 1'b1;
                expect_data = base;
                wdata       = ~base;
            end
            ST_READ_A: begin
                op          = OP_READ;
                needs_rsp   = 1'b1;
                expect_data = on_lock ? ~base : base;
            end
            ST_CNT_B: begin
                op          = OP_CNT_RW;
                col         = lock_col;
                sweep       = 1'b0;
                needs_rsp   = 1'b1;
                expect_data = ~base;
                wdata       = base;
            end
            ST_READ_B: begin
                op          = OP_READ;
                needs_rsp   = 1'b1;
                expect_data = base;
            end
            default: begin
                op = OP_WRITE;
            end
        endcase
    end

endmodule

// File: rtl/rtc_fail_trap.sv
module rtc_fail_trap #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear,
    input  logic              capture,
    input  logic [3:0]        step_code,
    input  logic [IDX_W-1:0]  idx,
    input  logic [DATA_W-1:0] expect_data,
    input  logic [DATA_W-1:0] actual_data,
    output logic              tripped,
    output logic [3:0]        trap_step,
    output logic [IDX_W-1:0]  trap_idx,
    output logic [DATA_W-1:0] trap_expect,
    output logic [DATA_W-1:0] trap_actual
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tripped     <= 1'b0;
            trap_step   <= '0;
            trap_idx    <= '0;
            trap_expect <= '0;
            trap_actual <= '0;
        end else if (clear) begin
            tripped     <= 1'b0;
            trap_step   <= '0;
            trap_idx    <= '0;
            trap_expect <= '0;
            trap_actual <= '0;
        end else if (capture && !tripped) begin
            tripped     <= 1'b1;
            trap_step   <= step_code;
            trap_idx    <= idx;
            trap_expect <= expect_data;
            trap_actual <= actual_data;
        end
    end

endmodule

// File: rtl/refcnt_test_seq.sv
module refcnt_test_seq
    import rtc_pkg::*;
#(
    parameter int ROWS        = 8,
    parameter int COLS        = 4,
    parameter int DATA_W      = 8,
    parameter int INIT_CYCLES = 8
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          start,
    input  logic [$clog2(COLS)-1:0]       test_col,
    output logic                          cmd_valid,
    input  logic                          cmd_ready,
    output logic [1:0]                    cmd_op,
    output logic [$clog2(ROWS)-1:0]       cmd_row,
    output logic [$clog2(COLS)-1:0]       cmd_col,
    output logic [DATA_W-1:0]             cmd_wdata,
    input  logic                          rsp_valid,
    input  logic [DATA_W-1:0]             rsp_rdata,
    output logic                          busy,
    output logic                          done,
    output logic                          pass,
    output logic                          fail,
    output logic [3:0]                    fail_step,
    output logic [$clog2(ROWS*COLS)-1:0]  fail_index,
    output logic [DATA_W-1:0]             fail_expect,
    output logic [DATA_W-1:0]             fail_actual
);
    localparam int ROW_W  = $clog2(ROWS);
    localparam int COL_W  = $clog2(COLS);
    localparam int IDX_W  = $clog2(ROWS * COLS);
    localparam int INIT_W = $clog2(INIT_CYCLES + 1);
    localparam logic [INIT_W-1:0] INIT_LAST = INIT_W'(INIT_CYCLES - 1);

    rtc_state_e          state_q, state_d;
    rtc_step_e           step_q;
    logic                phase_q;
    logic [COL_W-1:0]    col_lock;
    logic [INIT_W-1:0]   init_cnt;

    logic [ROW_W-1:0]    w_row;
    logic [COL_W-1:0]    w_col;
    logic [IDX_W-1:0]    w_idx;
    logic                w_last;

    rtc_op_e             g_op;
    logic [COL_W-1:0]    g_col;
    logic [DATA_W-1:0]   g_wdata;
    logic [DATA_W-1:0]   g_expect;
    logic                g_needs_rsp;
    logic                g_sweep;

    logic                launch;
    logic                cmd_fire;
    logic                issue_adv;
    logic                rsp_ok;
    logic                mismatch;
    logic                step_adv;
    logic                seq_end;
    logic                init_last;
    logic                walk_clear;
    logic [3:0]          step_code;

    // event decode shared by state and datapath
    always_comb begin
        launch    = start && (state_q == S_IDLE || state_q == S_DONE || state_q == S_STOP);
        cmd_fire  = cmd_valid && cmd_ready;
        issue_adv = (state_q == S_ISSUE) && cmd_fire && !g_needs_rsp;
        rsp_ok    = (state_q == S_WAIT) && rsp_valid && (rsp_rdata == g_expect);
        mismatch  = (state_q == S_WAIT) && rsp_valid && (rsp_rdata != g_expect);
        step_adv  = issue_adv || rsp_ok;
        seq_end   = step_adv && w_last && phase_q && (step_q == ST_READ_B);
        init_last = (state_q == S_INIT) && cmd_fire && (init_cnt == INIT_LAST);
        walk_clear = launch || (step_adv && w_last);
        step_code = 4'(step_q) + 4'd1 + (phase_q ? 4'(STEPS_PER_PASS) : 4'd0);
    end

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE, S_DONE, S_STOP: begin
                if (launch) state_d = S_INIT;
            end
            S_INIT: begin
                if (init_last) state_d = S_ISSUE;
            end
            S_ISSUE: begin
                if (cmd_fire) begin
                    if (g_needs_rsp)  state_d = S_WAIT;
                    else if (seq_end) state_d = S_DONE;
                end
            end
            S_WAIT: begin
                if (mismatch)     state_d = S_STOP;
                else if (seq_end) state_d = S_DONE;
                else if (rsp_ok)  state_d = S_ISSUE;
            end
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // step, pass and column bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            step_q   <= ST_FILL;
            phase_q  <= 1'b0;
            col_lock <= '0;
            init_cnt <= '0;
        end else if (launch) begin
            step_q   <= ST_FILL;
            phase_q  <= 1'b0;
            col_lock <= test_col;
            init_cnt <= '0;
        end else begin
            if ((state_q == S_INIT) && cmd_fire)
                init_cnt <= init_cnt + INIT_W'(1);
            if (step_adv && w_last && !seq_end) begin
                if (step_q == ST_READ_B) begin
                    step_q  <= ST_FILL;
                    phase_q <= 1'b1;
                end else begin
                    step_q <= rtc_step_e'(3'(step_q) + 3'd1);
                end
            end
        end
    end

    rtc_addr_walker #(
        .ROWS (ROWS),
        .COLS (COLS)
    ) u_walker (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear      (walk_clear),
        .adv        (step_adv),
        .sweep_cols (g_sweep),
        .row        (w_row),
        .col        (w_col),
        .idx        (w_idx),
        .last       (w_last)
    );

    rtc_pattern_gen #(
        .COLS   (COLS),
        .DATA_W (DATA_W)
    ) u_pattern (
        .step        (step_q),
        .phase       (phase_q),
        .walk_col    (w_col),
        .lock_col    (col_lock),
        .op          (g_op),
        .col         (g_col),
        .wdata       (g_wdata),
        .expect_data (g_expect),
        .needs_rsp   (g_needs_rsp),
        .sweep       (g_sweep)
    );

    rtc_fail_trap #(
        .DATA_W (DATA_W),
        .IDX_W  (IDX_W)
    ) u_trap (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear       (launch),
        .capture     (mismatch),
        .step_code   (step_code),
        .idx         (w_idx),
        .expect_data (g_expect),
        .actual_data (rsp_rdata),
        .tripped     (fail),
        .trap_step   (fail_step),
        .trap_idx    (fail_index),
        .trap_expect (fail_expect),
        .trap_actual (fail_actual)
    );

    // outputs
    always_comb begin
        cmd_valid = 1'b0;
        cmd_op    = 2'(OP_WRITE);
        cmd_row   = '0;
        cmd_col   = '0;
        cmd_wdata = '0;
        busy      = 1'b0;
        done      = 1'b0;
        pass      = 1'b0;
        unique case (state_q)
            S_IDLE: ;
            S_INIT: begin
                busy      = 1'b1;
                cmd_valid = 1'b1;
                cmd_op    = 2'(OP_INIT);
            end
            S_ISSUE: begin
                busy      = 1'b1;
                cmd_valid = 1'b1;
                cmd_op    = 2'(g_op);
                cmd_row   = g_sweep ? w_row : '0;
                cmd_col   = g_col;
                cmd_wdata = g_wdata;
            end
            S_WAIT: busy = 1'b1;
            S_DONE: begin
                done = 1'b1;
                pass = 1'b1;
            end
            S_STOP: done = 1'b1;
            default: ;
        endcase
    end

endmodule

// File: rtl/rtc_checker.sv
module rtc_checker #(
    parameter int COLS = 4
) (
    input logic                     clk,
    input logic                     rst_n,
    input logic                     start,
    input logic                     cmd_valid,
    input logic                     cmd_ready,
    input logic [1:0]               cmd_op,
    input logic [$clog2(COLS)-1:0]  cmd_col,
    input logic                     rsp_valid,
    input logic                     busy,
    input logic                     done,
    input logic                     pass,
    input logic                     fail,
    input logic [3:0]               fail_step,
    input logic [$clog2(COLS)-1:0]  col_lock
);
    logic outstanding;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            outstanding <= 1'b0;
        else if (cmd_valid && cmd_ready && (cmd_op == 2'd1 || cmd_op == 2'd2))
            outstanding <= 1'b1;
        else if (rsp_valid)
            outstanding <= 1'b0;
    end

    assert_cmd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_op) && $stable(cmd_col)));

    assert_one_outstanding_R9: assert property (@(posedge clk) disable iff (!rst_n)
        outstanding |-> !cmd_valid);

    assert_sweep_column_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_op == 2'd2) |-> (cmd_col == col_lock));

    assert_fail_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> (!cmd_valid && !busy));

    assert_fail_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (fail && !start) |=> (fail && $stable(fail_step)));

    assert_step_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> (fail_step >= 4'd1 && fail_step <= 4'd10));

    assert_pass_clean_R8: assert property (@(posedge clk) disable iff (!rst_n)
        pass |-> (done && !fail));

    assert_done_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_column_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (!busy || $stable(col_lock)));

endmodule

bind refcnt_test_seq rtc_checker #(.COLS(COLS)) u_rtc_checker (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_op    (cmd_op),
    .cmd_col   (cmd_col),
    .rsp_valid (rsp_valid),
    .busy      (busy),
    .done      (done),
    .pass      (pass),
    .fail      (fail),
    .fail_step (fail_step),
    .col_lock  (col_lock)
);

// File: tb/refcnt_test_seq_bench.sv
module refcnt_test_seq_bench;
    localparam int ROWS   = 8;
    localparam int COLS   = 4;
    localparam int DATA_W = 8;
    localparam int INITS  = 8;
    localparam int CELLS  = ROWS * COLS;
    localparam int TOTAL  = INITS + 2 * (3 * CELLS + 2 * ROWS);

    typedef struct packed {
        logic [1:0] gap;
        logic [1:0] dly;
        logic [2:0] fault;
        logic [1:0] tcol;
        logic       exp_pass;
        logic [3:0] exp_step;
        logic [4:0] exp_idx;
        logic [7:0] exp_e;
        logic [7:0] exp_a;
    } vec_t;

    // fault 0 none, 1 counter stalls, 2 counter skips a row,
    // 3 bit0 stuck low at row 5 / test column, 4 bit0 stuck low at row 2 / column 1
    localparam vec_t VECS [7] = '{
        '{2'd0, 2'd0, 3'd0, 2'd2, 1'b1, 4'd0, 5'd0,  8'h00, 8'h00},
        '{2'd2, 2'd1, 3'd0, 2'd0, 1'b1, 4'd0, 5'd0,  8'h00, 8'h00},
        '{2'd1, 2'd3, 3'd0, 2'd3, 1'b1, 4'd0, 5'd0,  8'h00, 8'h00},
        '{2'd0, 2'd0, 3'd1, 2'd2, 1'b0, 4'd2, 5'd1,  8'h00, 8'hFF},
        '{2'd1, 2'd2, 3'd2, 2'd1, 1'b0, 4'd2, 5'd4,  8'h00, 8'hFF},
        '{2'd0, 2'd1, 3'd3, 2'd2, 1'b0, 4'd3, 5'd22, 8'hFF, 8'hFE},
        '{2'd3, 2'd0, 3'd4, 2'd2, 1'b0, 4'd8, 5'd9,  8'hFF, 8'hFE}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [1:0]        test_col = '0;
    logic              cmd_valid;
    logic              cmd_ready = 1'b0;
    logic [1:0]        cmd_op;
    logic [2:0]        cmd_row;
    logic [1:0]        cmd_col;
    logic [7:0]        cmd_wdata;
    logic              rsp_valid = 1'b0;
    logic [7:0]        rsp_rdata = '0;
    logic              busy, done, pass, fail;
    logic [3:0]        fail_step;
    logic [4:0]        fail_index;
    logic [7:0]        fail_expect, fail_actual;

    always #4 clk = ~clk;

    refcnt_test_seq #(
        .ROWS(ROWS), .COLS(COLS), .DATA_W(DATA_W), .INIT_CYCLES(INITS)
    ) u_refcnt_test_seq (
        .clk(clk), .rst_n(rst_n), .start(start), .test_col(test_col),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_op(cmd_op),
        .cmd_row(cmd_row), .cmd_col(cmd_col), .cmd_wdata(cmd_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
        .busy(busy), .done(done), .pass(pass), .fail(fail),
        .fail_step(fail_step), .fail_index(fail_index),
        .fail_expect(fail_expect), .fail_actual(fail_actual)
    );

    int errors = 0;
    int checks = 0;
    int cyc = 0;
    logic wd = 1'b0;

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) wd <= 1'b1;
    end

    // controller model settings (written by the stimulus only)
    int m_gap = 0, m_dly = 0, m_fault = 0, m_col = 0;
    logic clr_req = 1'b0;

    // controller model state (written by the model only)
    logic [7:0] mem [ROWS][COLS];
    int rc, gap_cnt, dly_cnt, pend;
    logic [7:0] rd_word;
    int n_total, n_init, n_other, init_late, n_wr, wr_bad, n_rd, n_cnt, cnt_bad, cnt_col_bad;

    function automatic logic [7:0] stored(int r, int c, logic [7:0] w);
        logic [7:0] v = w;
        if (m_fault == 3 && r == 5 && c == m_col) v[0] = 1'b0;
        if (m_fault == 4 && r == 2 && c == 1) v[0] = 1'b0;
        return v;
    endfunction

    always @(negedge clk) begin
        rsp_valid = 1'b0;
        if (clr_req) begin
            for (int r = 0; r < ROWS; r++)
                for (int c = 0; c < COLS; c++) mem[r][c] = 8'h5A;
            rc = 5; gap_cnt = 0; dly_cnt = 0; pend = 0; cmd_ready = 1'b0;
            n_total = 0; n_init = 0; n_other = 0; init_late = 0; n_wr = 0; wr_bad = 0;
            n_rd = 0; n_cnt = 0; cnt_bad = 0; cnt_col_bad = 0;
        end else if (cmd_ready) begin
            cmd_ready = 1'b0;
        end else if (pend != 0) begin
            if (dly_cnt == 0) begin
                rsp_valid = 1'b1;
                rsp_rdata = rd_word;
                pend = 0;
            end else begin
                dly_cnt--;
            end
        end else if (cmd_valid) begin
            if (gap_cnt < m_gap) begin
                gap_cnt++;
            end else begin
                gap_cnt = 0;
                cmd_ready = 1'b1;
                n_total++;
                if (cmd_op != 2'd3) n_other++;
                case (cmd_op)
                    2'd3: begin
                        n_init++;
                        if (n_other > 0) init_late++;
                        rc = (rc + 1) % ROWS;
                    end
                    2'd0: begin
                        if (cmd_wdata != ((n_wr < CELLS) ? 8'h00 : 8'hFF)) wr_bad++;
                        mem[cmd_row][cmd_col] = stored(int'(cmd_row), int'(cmd_col), cmd_wdata);
                        n_wr++;
                    end
                    2'd1: begin
                        rd_word = mem[cmd_row][cmd_col];
                        pend = 1; dly_cnt = m_dly;
                        n_rd++;
                    end
                    default: begin
                        // expected write: sweep A writes ~P, sweep B writes P
                        logic [7:0] p;
                        p = ((n_cnt / (2 * ROWS)) != 0) ? 8'hFF : 8'h00;
                        if (cmd_wdata != ((((n_cnt % (2 * ROWS)) / ROWS) == 0) ? ~p : p)) cnt_bad++;
                        if (int'(cmd_col) != m_col) cnt_col_bad++;
                        rd_word = mem[rc][cmd_col];
                        mem[rc][cmd_col] = stored(rc, int'(cmd_col), cmd_wdata);
                        if (m_fault == 2)      rc = (rc + 2) % ROWS;
                        else if (m_fault != 1) rc = (rc + 1) % ROWS;
                        pend = 1; dly_cnt = m_dly;
                        n_cnt++;
                    end
                endcase
            end
        end
    end

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_clear();
        @(negedge clk); clr_req = 1'b1;
        @(negedge clk); clr_req = 1'b0;
    endtask

    task automatic pulse_start();
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
    endtask

    task automatic wait_done();
        while (!done && !wd) @(negedge clk);
    endtask

    initial begin
        // reset state, R11
        repeat (3) @(negedge clk);
        chk(!busy && !done && !pass && !fail && !cmd_valid, "R11", "outputs in reset", {busy, done, pass, fail, cmd_valid}, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && !done, "R11", "idle after reset", {busy, done}, 0);
        chk(!pass && !fail, "R11", "no verdict after reset", {pass, fail}, 0);
        chk(!cmd_valid, "R11", "no command after reset", cmd_valid, 0);

        foreach (VECS[i]) begin
            m_gap = VECS[i].gap; m_dly = VECS[i].dly; m_fault = VECS[i].fault; m_col = VECS[i].tcol;
            model_clear();
            test_col = VECS[i].tcol;
            pulse_start();
            chk(busy, "R8", "busy during run", busy, 1);
            wait_done();
            @(negedge clk);
            chk(done && !busy, "R8", "done at end", {done, busy}, 2);
            chk(pass == VECS[i].exp_pass, "R8", "pass verdict", pass, VECS[i].exp_pass);
            if (VECS[i].exp_pass) begin
                chk(!fail, "R7", "no fail on clean run", fail, 0);
                chk(n_init == INITS && init_late == 0, "R1", "init commands first", n_init, INITS);
                chk(n_wr == 2 * CELLS && wr_bad == 0, "R2", "fill writes", n_wr, 2 * CELLS);
                chk(n_cnt == 4 * ROWS && cnt_col_bad == 0, "R3", "counter sweeps on test column", n_cnt, 4 * ROWS);
                chk(cnt_bad == 0, "R5", "counter sweep write data", cnt_bad, 0);
                chk(n_rd == 4 * CELLS, "R4", "read-back count", n_rd, 4 * CELLS);
                chk(n_total == TOTAL, "R6", "both passes issued", n_total, TOTAL);
            end else begin
                int held;
                chk(fail, "R7", "fail set", fail, 1);
                chk(fail_step == VECS[i].exp_step, "R6", "failing step code", fail_step, VECS[i].exp_step);
                chk(fail_index == VECS[i].exp_idx, "R7", "failing index", fail_index, VECS[i].exp_idx);
                chk(fail_expect == VECS[i].exp_e, "R7", "expected word", fail_expect, VECS[i].exp_e);
                chk(fail_actual == VECS[i].exp_a, "R7", "received word", fail_actual, VECS[i].exp_a);
                held = n_total;
                repeat (20) @(negedge clk);
                chk(n_total == held, "R7", "no command after stop", n_total, held);
            end
        end

        // R10: start and test column change while busy are ignored
        m_gap = 0; m_dly = 1; m_fault = 0; m_col = 1;
        model_clear();
        test_col = 2'd1;
        pulse_start();
        repeat (40) @(negedge clk);
        test_col = 2'd3;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        wait_done();
        @(negedge clk);
        chk(pass, "R10", "run completes despite start pulse", pass, 1);
        chk(n_total == TOTAL, "R10", "command count unaffected", n_total, TOTAL);
        chk(cnt_col_bad == 0, "R10", "sweep column kept", cnt_col_bad, 0);

        // R9: held command with a long ready gap still completes in order
        m_gap = 3; m_dly = 3; m_fault = 0; m_col = 0;
        model_clear();
        test_col = 2'd0;
        pulse_start();
        wait_done();
        @(negedge clk);
        chk(pass && n_total == TOTAL, "R9", "handshake with slow controller", n_total, TOTAL);

        if (wd) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
        end
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        wait (wd);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 150000);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule